// File: doc/BRIEF.md
# Linear Reconfigurable ALU Array

This block is a row of sixteen identical 4-bit arithmetic/logic processing elements that share one pair of operand buses and one pair of result buses. Each element holds its own 4-bit operation code, so the row can be loaded with a mix of functions, such as an adder in one slot, a subtracter in another and a logic gate in a third. A one-hot select vector picks which element sees the operands and drives the result buses in a given cycle. The result bus is registered, so a result appears one clock after its select and operands.

Operation codes are written through a separate write-enable vector that has one bit per element. Any subset of elements can be loaded with the same code in one cycle. A write can happen while the array is computing, including on the element that is selected in that cycle. In that case the operation issued in the write cycle uses the code the element held before the write, and the new code applies from the following cycle.

Top module: `rla_array`

## Requirements
- R1: While `rst` is high at a rising edge, `res_s` and `res_cout` become 0 and every element's operation code becomes 0 (ADD).
- R2: `pe_sel` must be one-hot or all-zero. When exactly bit k is high, the edge captures element k's result for `op_a`/`op_b` under element k's code, and that result is on `res_s`/`res_cout` until the next edge.
- R3: When `pe_sel` is all-zero, `res_s` and `res_cout` are 0 after the next edge, whatever the operands are.
- R4: Arithmetic codes give a 5-bit result {cout,s}. Code 0 is a+b. Code 1 is a+b+1. Code 2 is a+~b+1 (subtract; cout=1 means no borrow). Code 3 is ~a+b+1. Code 4 is a+1. Code 5 is a+15 (decrement; cout=1 when a≠0).
- R5: Logic codes give cout=0 and a bitwise s. Code 6 is AND, 7 is OR, 8 is XOR, 9 is NAND, 10 is NOR, 11 is XNOR, 12 passes a, 13 passes b, 14 is NOT a, and 15 is a AND NOT b.
- R6: At an edge, every element whose `cfg_wen` bit is high loads `cfg_word`, so several elements can be loaded at once. Elements whose bit is low keep their code.
- R7: If an element is selected in the same cycle its code is written, the result of that cycle uses the old code. The new code applies from the next cycle.
- R8: Different elements hold and apply different codes at the same time. Selecting another element changes the operation without any code write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pe_sel | input | 16 | One-hot element select for the shared buses |
| op_a | input | 4 | Shared operand A |
| op_b | input | 4 | Shared operand B |
| cfg_wen | input | 16 | Per-element operation-code write enable |
| cfg_word | input | 4 | Operation code to write |
| res_s | output | 4 | Registered result of the selected element |
| res_cout | output | 1 | Registered carry-out of the selected element |

## Verification
Two functions can fall in the same cycle: an operation issued to an element, and a rewrite of that same element's code. The bench provokes this by asserting a select bit and the matching write-enable bit together, with a code that gives a different result for the same operands. It then repeats the operands in the next cycle. The scoreboard computes the expected value of the first cycle from the old code and that of the second from the new one, so it catches a design that lets the write reach the datapath early or one that drops it.

// File: rtl/rla_pkg.sv
package rla_pkg;

    localparam int DATA_W = 4;
    localparam int NUM_PE = 16;
    localparam int CFG_W  = 4;

    typedef enum logic [3:0] {
        OP_ADD   = 4'd0,
        OP_ADD1  = 4'd1,
        OP_SUB   = 4'd2,
        OP_RSUB  = 4'd3,
        OP_INC   = 4'd4,
        OP_DEC   = 4'd5,
        OP_AND   = 4'd6,
        OP_OR    = 4'd7,
        OP_XOR   = 4'd8,
        OP_NAND  = 4'd9,
        OP_NOR   = 4'd10,
        OP_XNOR  = 4'd11,
        OP_PASSA = 4'd12,
        OP_PASSB = 4'd13,
        OP_NOTA  = 4'd14,
        OP_ANDN  = 4'd15
    } op_e;

    typedef enum logic [1:0] {
        Y_B    = 2'd0,
        Y_NB   = 2'd1,
        Y_ZERO = 2'd2,
        Y_ONES = 2'd3
    } ysel_e;

    // Slice controls: arithmetic path selects x/y preconditioning and carry-in,
    // logic path uses a 2-input truth table indexed by {a,b}.
    typedef struct packed {
        logic       arith;
        logic       inv_a;
        ysel_e      ysel;
        logic       cin;
        logic [3:0] tt;
    } ctl_t;

    function automatic ctl_t decode_op(input logic [3:0] code);
        ctl_t c;
        c.arith = 1'b0;
        c.inv_a = 1'b0;
        c.ysel  = Y_B;
        c.cin   = 1'b0;
        c.tt    = 4'b0000;
        case (op_e'(code))
            OP_ADD:   begin c.arith = 1'b1; end
            OP_ADD1:  begin c.arith = 1'b1; c.cin = 1'b1; end
            OP_SUB:   begin c.arith = 1'b1; c.ysel = Y_NB; c.cin = 1'b1; end
            OP_RSUB:  begin c.arith = 1'b1; c.inv_a = 1'b1; c.cin = 1'b1; end
            OP_INC:   begin c.arith = 1'b1; c.ysel = Y_ZERO; c.cin = 1'b1; end
            OP_DEC:   begin c.arith = 1'b1; c.ysel = Y_ONES; end
            OP_AND:   c.tt = 4'b1000;
            OP_OR:    c.tt = 4'b1110;
            OP_XOR:   c.tt = 4'b0110;
            OP_NAND:  c.tt = 4'b0111;
            OP_NOR:   c.tt = 4'b0001;
            OP_XNOR:  c.tt = 4'b1001;
            OP_PASSA: c.tt = 4'b1100;
            OP_PASSB: c.tt = 4'b1010;
            OP_NOTA:  c.tt = 4'b0011;
            OP_ANDN:  c.tt = 4'b0100;
            default:  c.tt = 4'b0000;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/rla_slice.sv
module rla_slice
    import rla_pkg::*;
(
    input  logic a,
    input  logic b,
    input  logic ci,
    input  ctl_t ctl,
    output logic s,
    output logic co
);
    logic x;
    logic y;
    logic sum;
    logic lg;

    always_comb begin
        x = a ^ ctl.inv_a;
        case (ctl.ysel)
            Y_B:     y = b;
            Y_NB:    y = ~b;
            Y_ZERO:  y = 1'b0;
            default: y = 1'b1;
        endcase
        sum = x ^ y ^ ci;
        co  = (x & y) | (x & ci) | (y & ci);
        lg  = ctl.tt[{a, b}];
        s   = ctl.arith ? sum : lg;
    end
endmodule

// File: rtl/rla_cfg_reg.sv
module rla_cfg_reg #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wen,
    input  logic [CW-1:0] din,
    output logic [CW-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (wen)
            q <= din;
    end
endmodule

// File: rtl/rla_pe.sv
module rla_pe
    import rla_pkg::*;
#(
    parameter int W  = 4,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_wen,
    input  logic [CW-1:0] cfg_word,
    input  logic          grant,
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    output logic [W-1:0]  s_g,
    output logic          cout_g,
    output logic [CW-1:0] cfg_q
);
    ctl_t         ctl;
    logic [W:0]   carry;
    logic [W-1:0] s_raw;

    rla_cfg_reg #(.CW(CW)) cfg_i (
        .clk (clk),
        .rst (rst),
        .wen (cfg_wen),
        .din (cfg_word),
        .q   (cfg_q)
    );

    assign ctl      = decode_op(cfg_q[3:0]);
    assign carry[0] = ctl.cin;

    for (genvar i = 0; i < W; i++) begin : g_slice
        rla_slice slice_i (
            .a   (a[i]),
            .b   (b[i]),
            .ci  (carry[i]),
            .ctl (ctl),
            .s   (s_raw[i]),
            .co  (carry[i+1])
        );
    end

    // Only a granted element puts anything on the shared result lines.
    assign s_g    = grant ? s_raw : '0;
    assign cout_g = grant & ctl.arith & carry[W];
endmodule

// File: rtl/rla_merge.sv
module rla_merge #(
    parameter int N = 16,
    parameter int W = 4
) (
    input  logic [N*W-1:0] s_vec,
    input  logic [N-1:0]   c_vec,
    output logic [W-1:0]   s_out,
    output logic           c_out
);
    always_comb begin
        s_out = '0;
        for (int k = 0; k < N; k++)
            s_out = s_out | s_vec[k*W +: W];
        c_out = |c_vec;
    end
endmodule

// File: rtl/rla_array.sv
module rla_array
    import rla_pkg::*;
#(
    parameter int NUM_PE_P = NUM_PE,
    parameter int DATA_W_P = DATA_W,
    parameter int CFG_W_P  = CFG_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PE_P-1:0] pe_sel,
    input  logic [DATA_W_P-1:0] op_a,
    input  logic [DATA_W_P-1:0] op_b,
    input  logic [NUM_PE_P-1:0] cfg_wen,
    input  logic [CFG_W_P-1:0]  cfg_word,
    output logic [DATA_W_P-1:0] res_s,
    output logic                res_cout
);
    localparam int SV_W  = NUM_PE_P * DATA_W_P;
    localparam int CFG_T = NUM_PE_P * CFG_W_P;

    logic [SV_W-1:0]     s_vec;
    logic [NUM_PE_P-1:0] c_vec;
    logic [CFG_T-1:0]    cfg_flat;
    logic [DATA_W_P-1:0] s_bus;
    logic                c_bus;

    for (genvar k = 0; k < NUM_PE_P; k++) begin : g_pe
        rla_pe #(.W(DATA_W_P), .CW(CFG_W_P)) pe_i (
            .clk      (clk),
            .rst      (rst),
            .cfg_wen  (cfg_wen[k]),
            .cfg_word (cfg_word),
            .grant    (pe_sel[k]),
            .a        (op_a),
            .b        (op_b),
            .s_g      (s_vec[k*DATA_W_P +: DATA_W_P]),
            .cout_g   (c_vec[k]),
            .cfg_q    (cfg_flat[k*CFG_W_P +: CFG_W_P])
        );
    end

    rla_merge #(.N(NUM_PE_P), .W(DATA_W_P)) merge_i (
        .s_vec (s_vec),
        .c_vec (c_vec),
        .s_out (s_bus),
        .c_out (c_bus)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_s    <= '0;
            res_cout <= 1'b0;
        end else begin
            res_s    <= s_bus;
            res_cout <= c_bus;
        end
    end
endmodule

// File: rtl/rla_array_chk.sv
module rla_array_chk #(
    parameter int NUM_PE_P = 16,
    parameter int DATA_W_P = 4,
    parameter int CFG_W_P  = 4
) (
    input logic                         clk,
    input logic                         rst,
    input logic [NUM_PE_P-1:0]          pe_sel,
    input logic [NUM_PE_P-1:0]          cfg_wen,
    input logic [CFG_W_P-1:0]           cfg_word,
    input logic [DATA_W_P-1:0]          res_s,
    input logic                         res_cout,
    input logic [NUM_PE_P*CFG_W_P-1:0]  cfg_flat
);
    AST_RST_CLEAR: assert property (@(posedge clk)
        rst |=> (res_s == '0) && !res_cout); // R1

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pe_sel)); // R2

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (pe_sel == '0) |=> (res_s == '0) && !res_cout); // R3

    for (genvar k = 0; k < NUM_PE_P; k++) begin : g_pe_chk
        AST_LOGIC_NO_CARRY: assert property (@(posedge clk) disable iff (rst)
            (pe_sel[k] && (cfg_flat[k*CFG_W_P +: CFG_W_P] >= CFG_W_P'(6))) |=> !res_cout); // R5

        AST_CFG_LOAD: assert property (@(posedge clk) disable iff (rst)
            cfg_wen[k] |=> (cfg_flat[k*CFG_W_P +: CFG_W_P] == $past(cfg_word))); // R6

        AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
            !cfg_wen[k] |=> $stable(cfg_flat[k*CFG_W_P +: CFG_W_P])); // R6
    end
endmodule

bind rla_array rla_array_chk #(
    .NUM_PE_P (NUM_PE_P),
    .DATA_W_P (DATA_W_P),
    .CFG_W_P  (CFG_W_P)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .pe_sel   (pe_sel),
    .cfg_wen  (cfg_wen),
    .cfg_word (cfg_word),
    .res_s    (res_s),
    .res_cout (res_cout),
    .cfg_flat (cfg_flat)
);

// File: tb/rla_array_tb_top.sv
module rla_array_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] pe_sel;
    logic [3:0]  op_a;
    logic [3:0]  op_b;
    logic [15:0] cfg_wen;
    logic [3:0]  cfg_word;
    logic [3:0]  res_s;
    logic        res_cout;

    int checks   = 0;
    int failures = 0;
    logic [3:0] mcfg [16];

    typedef struct {
        logic [4:0] exp;
        string      req;
    } item_t;
    item_t sb[$];

    always #4 clk = ~clk;

    rla_array dut_i (
        .clk      (clk),
        .rst      (rst),
        .pe_sel   (pe_sel),
        .op_a     (op_a),
        .op_b     (op_b),
        .cfg_wen  (cfg_wen),
        .cfg_word (cfg_word),
        .res_s    (res_s),
        .res_cout (res_cout)
    );

    function automatic logic [4:0] model(input logic [3:0] code, input logic [3:0] a, input logic [3:0] b);
        logic [3:0] na = ~a;
        logic [3:0] nb = ~b;
        case (code)
            4'd0:  return {1'b0, a} + {1'b0, b};
            4'd1:  return {1'b0, a} + {1'b0, b} + 5'd1;
            4'd2:  return {1'b0, a} + {1'b0, nb} + 5'd1;
            4'd3:  return {1'b0, na} + {1'b0, b} + 5'd1;
            4'd4:  return {1'b0, a} + 5'd1;
            4'd5:  return {1'b0, a} + 5'd15;
            4'd6:  return {1'b0, a & b};
            4'd7:  return {1'b0, a | b};
            4'd8:  return {1'b0, a ^ b};
            4'd9:  return {1'b0, ~(a & b)};
            4'd10: return {1'b0, ~(a | b)};
            4'd11: return {1'b0, ~(a ^ b)};
            4'd12: return {1'b0, a};
            4'd13: return {1'b0, b};
            4'd14: return {1'b0, na};
            default: return {1'b0, a & nb};
        endcase
    endfunction

    task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual={cout,s}=%b expected=%b", req, act, exp);
        end
    endtask

    // Driver: called at a falling edge, drives one cycle and queues the expectation.
    task automatic issue(input logic [15:0] sel, input logic [3:0] a, input logic [3:0] b,
                         input logic [15:0] wen, input logic [3:0] wd, input string req);
        item_t it;
        pe_sel   = sel;
        op_a     = a;
        op_b     = b;
        cfg_wen  = wen;
        cfg_word = wd;
        it.exp = 5'd0;
        for (int k = 0; k < 16; k++)
            if (sel[k]) it.exp = model(mcfg[k], a, b);
        it.req = req;
        sb.push_back(it);
        for (int k = 0; k < 16; k++)
            if (wen[k]) mcfg[k] = wd;
        @(negedge clk);
    endtask

    // Monitor: compares just after the edge that registered the queued cycle.
    always @(posedge clk) begin
        #2;
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            check(it.req, {res_cout, res_s}, it.exp);
        end
    end

    logic finished = 1'b0;

    initial begin
        #(8 * 150000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        rst = 1'b1;
        pe_sel = '0; op_a = 4'hF; op_b = 4'hF; cfg_wen = '1; cfg_word = 4'd9;
        for (int k = 0; k < 16; k++) mcfg[k] = 4'd0;
        repeat (3) @(negedge clk);
        // R1: outputs cleared during reset even with write enables active
        check("R1", {res_cout, res_s}, 5'd0);
        cfg_wen = '0;
        @(negedge clk);
        rst = 1'b0;

        // R1: every element comes out of reset as ADD (9+8 = 17)
        for (int k = 0; k < 16; k++)
            issue(16'd1 << k, 4'd9, 4'd8, 16'd0, 4'd0, "R1");

        // R3: nothing selected gives zero, even while codes are written
        for (int k = 0; k < 16; k++)
            issue(16'd0, 4'hF, 4'hE, 16'd1 << k, 4'(k), "R3");

        // R4/R5/R8: each element now runs its own code
        for (int k = 0; k < 16; k++) begin
            issue(16'd1 << k, 4'd6, 4'd3,  16'd0, 4'd0, (k < 6) ? "R4" : "R5");
            issue(16'd1 << k, 4'd0, 4'hF,  16'd0, 4'd0, (k < 6) ? "R4" : "R5");
            issue(16'd1 << k, 4'hA, 4'hC,  16'd0, 4'd0, (k < 6) ? "R4" : "R8");
        end

        // R4 corners: subtract with borrow, decrement of zero, increment wrap
        issue(16'd1 << 2, 4'd3, 4'd5, 16'd0, 4'd0, "R4");
        issue(16'd1 << 5, 4'd0, 4'd0, 16'd0, 4'd0, "R4");
        issue(16'd1 << 4, 4'hF, 4'd0, 16'd0, 4'd0, "R4");

        // R6: broadcast one code to a subset; the rest must keep theirs
        issue(16'd0, 4'd0, 4'd0, 16'hF0F0, 4'd7, "R3");
        for (int k = 0; k < 16; k++)
            issue(16'd1 << k, 4'h5, 4'h9, 16'd0, 4'd0, "R6");

        // R7: write the selected element in the same cycle, then reuse operands
        issue(16'd1 << 3, 4'd6, 4'd2, 16'd1 << 3, 4'd0, "R7");
        issue(16'd1 << 3, 4'd6, 4'd2, 16'd0,      4'd0, "R7");
        issue(16'd1 << 8, 4'd6, 4'd2, 16'hFFFF,   4'd2, "R7");
        issue(16'd1 << 8, 4'd6, 4'd2, 16'd0,      4'd0, "R7");

        // R2: mixed traffic with occasional idle cycles and code writes
        lfsr = 16'hACE1;
        for (int n = 0; n < 300; n++) begin
            logic [15:0] sel;
            logic [15:0] wen;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            sel = (lfsr[7:5] == 3'd0) ? 16'd0 : (16'd1 << lfsr[3:0]);
            wen = lfsr[8] ? (16'd1 << lfsr[11:8]) : 16'd0;
            issue(sel, lfsr[15:12], lfsr[11:8] ^ lfsr[4:1], wen, lfsr[3:0] ^ lfsr[14:11], "R2");
        end

        pe_sel = '0; cfg_wen = '0;
        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule